// File: doc/BRIEF.md
# Network Loop-Code Detector

This block watches a serial receive bit stream for two repeating in-band codes. The loop-up code repeats the 5-bit pattern `00001` and the loop-down code repeats the 3-bit pattern `001`. Only bits that arrive with the bit-enable strobe are used. A one-second tick input times how long the watched code stays present. A code is accepted once it has persisted past a programmable number of ticks.

A two-bit mode field selects the behaviour:

- **Disabled** holds everything idle.
- **Manual** is a live presence indicator for one code.
- **Automatic** is a latched state machine:
  - A sustained loop-up code raises the status bit and the remote loopback control.
  - The block then watches only for the loop-down code.
  - Status and loopback stay high until a sustained loop-down code clears both.

Every change of the status bit can set a sticky interrupt flag. The host clears the flag with a one-cycle pulse.

Top module: `loop_code_detector`

## Requirements
- R1: After reset `detectStatus`, `remoteLoopback` and `irqFlag` are 0.
- R2: The loop-up code is present when the last 15 accepted bits repeat with period 5 and every 5-bit window holds exactly one 1 (the pattern `00001` in any phase).
- R3: The loop-down code is present when the last 15 accepted bits repeat with period 3 and every 3-bit window holds exactly one 1 (the pattern `001` in any phase).
- R4: The persistence timer counts `secTick` pulses while the watched code is present. A code qualifies on the tick that takes the count past `THRESH_TICKS` (default 5), so qualification happens on the 6th tick. `detectStatus` changes one cycle after that tick.
- R5: An accepted bit that breaks the watched code restarts the timer from zero. A later qualification then needs the full threshold again.
- R6: Manual mode watches the loop-up code when `modeSel`=01 and the loop-down code when `modeSel`=10.
  - The other code never qualifies.
  - `detectStatus` follows qualification and returns to 0 one cycle after a breaking bit.
  - `remoteLoopback` stays 0.
- R7: With `modeSel`=00, `detectStatus` and `remoteLoopback` stay 0 whatever codes and ticks arrive.
- R8: Entering automatic mode (`modeSel`=11) clears `detectStatus` to 0 and watches only the loop-up code. A sustained loop-up code then sets `detectStatus` and `remoteLoopback` in the same cycle.
- R9: In automatic mode, once looped, `detectStatus` and `remoteLoopback` stay 1 after the loop-up code stops. Both fall together when the loop-down code has qualified.
- R10: With `irqEnable`=1, every rising or falling change of `detectStatus` sets `irqFlag` in the same cycle. The flag stays set until an `irqClear` pulse. With `irqEnable`=0 the flag is never set.
- R11: Any change of `modeSel` restarts the persistence timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Received data bit |
| rxBitValid | input | 1 | Qualifies `rxBit` for one cycle |
| secTick | input | 1 | One-cycle pulse once per second |
| modeSel | input | 2 | 00 off, 01 manual loop-up, 10 manual loop-down, 11 automatic |
| irqEnable | input | 1 | Allows status changes to set the interrupt flag |
| irqClear | input | 1 | One-cycle pulse that clears the interrupt flag |
| detectStatus | output | 1 | Loop-code detection status |
| remoteLoopback | output | 1 | Remote loopback request (automatic mode only) |
| irqFlag | output | 1 | Sticky interrupt flag |

## Verification
The hardest state to reach from the ports is the latched loopback held across a code change in automatic mode. The loop-up code has to persist through six ticks. The stream then switches to the loop-down code, and that code must build its own six-tick persistence while status must not move. The stimulus therefore keeps a running phase for each code and refills the 15-bit history before each group of ticks. The bench checks the status on the fifth and sixth tick of each phase so that an off-by-one threshold shows up.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int UP_LEN = 5;
  localparam logic [UP_LEN-1:0] UP_CODE = 5'b00001;
  localparam int DOWN_LEN = 3;
  localparam logic [DOWN_LEN-1:0] DOWN_CODE = 3'b001;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_MAN_UP = 2'b01,
    MODE_MAN_DN = 2'b10,
    MODE_AUTO   = 2'b11
  } lcd_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic watchUp;
    logic clearTimer;
  } lcd_ctrl_t;
endpackage

// File: rtl/lcd_pattern_match.sv
module lcd_pattern_match #(
  parameter int HIST_LEN = 15,
  parameter int CODE_LEN = 5,
  parameter logic [CODE_LEN-1:0] CODE = '0
) (
  input  logic [HIST_LEN-1:0] history,
  output logic                present
);
  localparam int CMP_N = HIST_LEN - CODE_LEN;

  logic periodic;
  logic phaseHit;
  logic [2*CODE_LEN-1:0] doubled;

  always_comb begin
    periodic = 1'b1;
    for (int i = 0; i < CMP_N; i++) begin
      if (history[i] != history[i+CODE_LEN]) periodic = 1'b0;
    end
    doubled = {CODE, CODE};
    phaseHit = 1'b0;
    for (int r = 0; r < CODE_LEN; r++) begin
      if (history[CODE_LEN-1:0] == doubled[r +: CODE_LEN]) phaseHit = 1'b1;
    end
    present = periodic && phaseHit;
  end
endmodule

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter int HIST_LEN = 15,
  parameter int THRESH_TICKS = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxBit,
  input  logic      rxBitValid,
  input  logic      secTick,
  input  lcd_ctrl_t ctrl,
  output logic      codeQualified
);
  localparam int CNT_MAX = THRESH_TICKS + 1;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [HIST_LEN-1:0] history;
  logic [CNT_W-1:0] tickCount;
  logic upPresent, downPresent, watchedPresent;

  // newest bit at index 0; all-ones reset matches neither code
  always_ff @(posedge clk) begin
    if (!rstN) history <= '1;
    else if (rxBitValid) history <= {history[HIST_LEN-2:0], rxBit};
  end

  lcd_pattern_match #(.HIST_LEN(HIST_LEN), .CODE_LEN(UP_LEN), .CODE(UP_CODE))
    upMatch_i (.history(history), .present(upPresent));
  lcd_pattern_match #(.HIST_LEN(HIST_LEN), .CODE_LEN(DOWN_LEN), .CODE(DOWN_CODE))
    downMatch_i (.history(history), .present(downPresent));

  assign watchedPresent = ctrl.watchUp ? upPresent : downPresent;

  always_ff @(posedge clk) begin
    if (!rstN) tickCount <= '0;
    else if (ctrl.clearTimer || !watchedPresent) tickCount <= '0;
    else if (secTick && tickCount != CNT_W'(CNT_MAX)) tickCount <= tickCount + 1'b1;
  end

  assign codeQualified = watchedPresent && (tickCount > CNT_W'(THRESH_TICKS));

  // R4: the counter saturates one above the threshold
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    tickCount <= CNT_W'(CNT_MAX));
  // R5, R11: a restart empties the timer
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clearTimer || !watchedPresent) |=> tickCount == '0);
endmodule

// File: rtl/lcd_control.sv
module lcd_control
  import lcd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] modeSel,
  input  logic      codeQualified,
  input  logic      irqEnable,
  input  logic      irqClear,
  output lcd_ctrl_t ctrl,
  output logic      detectStatus,
  output logic      remoteLoopback,
  output logic      irqFlag
);
  lcd_mode_e mode, modeQ;
  logic modeChanged;
  logic statusNext, loopedNext;

  assign mode = lcd_mode_e'(modeSel);
  assign modeChanged = (mode != modeQ);

  always_comb begin
    ctrl.watchUp = 1'b1;
    if (mode == MODE_MAN_DN) ctrl.watchUp = 1'b0;
    else if (mode == MODE_AUTO) ctrl.watchUp = !remoteLoopback;
    ctrl.clearTimer = modeChanged || (mode == MODE_OFF) ||
                      ((mode == MODE_AUTO) && codeQualified);
  end

  always_comb begin
    statusNext = 1'b0;
    loopedNext = 1'b0;
    if (mode == MODE_OFF || modeChanged) begin
      statusNext = 1'b0;
      loopedNext = 1'b0;
    end else if (mode == MODE_AUTO) begin
      loopedNext = codeQualified ? !remoteLoopback : remoteLoopback;
      statusNext = loopedNext;
    end else begin
      statusNext = codeQualified;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
      detectStatus <= 1'b0;
      remoteLoopback <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      modeQ <= mode;
      detectStatus <= statusNext;
      remoteLoopback <= loopedNext;
      if (irqEnable && statusNext != detectStatus) irqFlag <= 1'b1;
      else if (irqClear) irqFlag <= 1'b0;
    end
  end

  // R7: disabled mode idles the outputs
  a_r7_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00) |=> (!detectStatus && !remoteLoopback));
  // R6: loopback only in automatic mode
  a_r6_manual_no_loop: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 || modeSel == 2'b10) |=> !remoteLoopback);
  // R8: entering automatic clears status
  a_r8_auto_entry_clear: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11 && modeQ != MODE_AUTO) |=> !detectStatus);
  // R9: status and loopback move together in automatic mode
  a_r9_auto_tied: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |=> (detectStatus == remoteLoopback));
  // R10: an enabled status change raises the flag
  a_r10_irq_on_change: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqEnable) && detectStatus != $past(detectStatus)) |-> irqFlag);
endmodule

// File: rtl/loop_code_detector.sv
module loop_code_detector
  import lcd_pkg::*;
#(
  parameter int HIST_LEN = 15,
  parameter int THRESH_TICKS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxBit,
  input  logic       rxBitValid,
  input  logic       secTick,
  input  logic [1:0] modeSel,
  input  logic       irqEnable,
  input  logic       irqClear,
  output logic       detectStatus,
  output logic       remoteLoopback,
  output logic       irqFlag
);
  lcd_ctrl_t ctrl;
  logic codeQualified;

  lcd_datapath #(.HIST_LEN(HIST_LEN), .THRESH_TICKS(THRESH_TICKS)) datapath_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxBitValid(rxBitValid),
    .secTick(secTick), .ctrl(ctrl), .codeQualified(codeQualified));

  lcd_control control_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .codeQualified(codeQualified),
    .irqEnable(irqEnable), .irqClear(irqClear), .ctrl(ctrl),
    .detectStatus(detectStatus), .remoteLoopback(remoteLoopback), .irqFlag(irqFlag));
endmodule

// File: tb/loop_code_detector_tb.sv
module loop_code_detector_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxBit = 1'b0, rxBitValid = 1'b0, secTick = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic irqEnable = 1'b0, irqClear = 1'b0;
  logic detectStatus, remoteLoopback, irqFlag;

  int checks = 0;
  int failures = 0;
  int phase = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_code_detector dut_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .rxBitValid(rxBitValid),
    .secTick(secTick), .modeSel(modeSel), .irqEnable(irqEnable),
    .irqClear(irqClear), .detectStatus(detectStatus),
    .remoteLoopback(remoteLoopback), .irqFlag(irqFlag));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic codeBit(input bit isUp, input int ph);
    return isUp ? ((ph % 5) == 4) : ((ph % 3) == 2);
  endfunction

  task automatic sendCode(input bit isUp, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxBit = codeBit(isUp, phase);
      rxBitValid = 1'b1;
      phase++;
    end
    @(negedge clk);
    rxBitValid = 1'b0;
  endtask

  task automatic sendBreak(input bit isUp);
    @(negedge clk);
    rxBit = !codeBit(isUp, phase);
    rxBitValid = 1'b1;
    @(negedge clk);
    rxBitValid = 1'b0;
    phase = 0;
  endtask

  // n tick pulses, then one settle cycle for the status register
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1'b1;
      @(negedge clk); secTick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeSel = m;
    @(negedge clk);
  endtask

  task automatic clearIrq();
    @(negedge clk); irqClear = 1'b1;
    @(negedge clk); irqClear = 1'b0;
  endtask

  task automatic testReset();
    check("R1 status", detectStatus, 1'b0);
    check("R1 loopback", remoteLoopback, 1'b0);
    check("R1 irq", irqFlag, 1'b0);
  endtask

  task automatic testManualUp();
    irqEnable = 1'b1;
    setMode(2'b01);
    phase = 0;
    sendCode(1'b1, 20);
    ticks(5);
    check("R4 up below threshold", detectStatus, 1'b0);
    check("R10 no irq yet", irqFlag, 1'b0);
    ticks(1);
    check("R2 up qualifies on 6th tick", detectStatus, 1'b1);
    check("R6 manual no loopback", remoteLoopback, 1'b0);
    check("R10 irq on rise", irqFlag, 1'b1);
    clearIrq();
    check("R10 irq cleared", irqFlag, 1'b0);
    sendBreak(1'b1);
    @(negedge clk);
    check("R6 status drops on break", detectStatus, 1'b0);
    check("R10 irq on fall", irqFlag, 1'b1);
    clearIrq();
  endtask

  task automatic testRestart();
    sendCode(1'b1, 20);
    ticks(3);
    sendBreak(1'b1);
    sendCode(1'b1, 20);
    ticks(5);
    check("R5 timer restarted", detectStatus, 1'b0);
    ticks(1);
    check("R5 full threshold after restart", detectStatus, 1'b1);
  endtask

  task automatic testManualDown();
    setMode(2'b10);
    phase = 0;
    sendCode(1'b0, 20);
    ticks(5);
    check("R3 down below threshold", detectStatus, 1'b0);
    ticks(1);
    check("R3 down qualifies", detectStatus, 1'b1);
    phase = 0;
    sendCode(1'b1, 20);
    check("R6 up code ignored in 10", detectStatus, 1'b0);
    ticks(6);
    check("R6 up never qualifies in 10", detectStatus, 1'b0);
  endtask

  task automatic testOff();
    setMode(2'b00);
    phase = 0;
    sendCode(1'b1, 20);
    ticks(7);
    check("R7 off status", detectStatus, 1'b0);
    check("R7 off loopback", remoteLoopback, 1'b0);
  endtask

  task automatic testAuto();
    setMode(2'b01);
    ticks(6);
    check("R6 precondition status", detectStatus, 1'b1);
    clearIrq();
    @(negedge clk); modeSel = 2'b11;
    @(negedge clk);
    check("R8 entry clears status", detectStatus, 1'b0);
    check("R10 irq on entry clear", irqFlag, 1'b1);
    ticks(5);
    check("R11 mode change restarts timer", detectStatus, 1'b0);
    ticks(1);
    check("R8 status set", detectStatus, 1'b1);
    check("R8 loopback set", remoteLoopback, 1'b1);
    sendBreak(1'b1);
    @(negedge clk);
    check("R9 latched after up stops", detectStatus, 1'b1);
    phase = 0;
    sendCode(1'b0, 20);
    ticks(5);
    check("R9 hold status before down qualifies", detectStatus, 1'b1);
    check("R9 hold loopback", remoteLoopback, 1'b1);
    clearIrq();
    ticks(1);
    check("R9 status cleared by down", detectStatus, 1'b0);
    check("R9 loopback cleared by down", remoteLoopback, 1'b0);
    check("R10 irq on auto clear", irqFlag, 1'b1);
  endtask

  task automatic testIrqDisabled();
    clearIrq();
    irqEnable = 1'b0;
    setMode(2'b01);
    phase = 0;
    sendCode(1'b1, 20);
    ticks(6);
    check("R10 status rose", detectStatus, 1'b1);
    check("R10 disabled no irq", irqFlag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testManualUp();
    testRestart();
    testManualDown();
    testOff();
    testAuto();
    testIrqDisabled();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule